// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit and Selectable Output Timing

This block is a first-in first-out buffer between two unrelated clock domains. A producer writes words on the write clock and a consumer reads them on the read clock. Pointers pass from one domain to the other as Gray codes through two-flop synchronizers. The depth is a power of two (eight words by default). The write side drives a space-available status and a half-full flag. The read side drives a data-available status and a registered data output.

Output timing is chosen while master reset is held low. In standard timing a word reaches the output only after a read request. In fall-through timing the oldest word is loaded into the output register by itself, and a read request moves the output to the next word. A partial reset empties the buffer but keeps the timing choice. Retransmit rewinds only the read pointer, so data stored since the last reset can be read again from the first memory location. A read chip select gates every read request. An output-enable input qualifies the data-valid output.

Top module: `fifo_rt_top`

## Requirements
- R1: While `mrst_n` is low at the clock edges, both pointers go to zero and `q` is all zeros. After release, `rd_stat`=0, `wr_stat`=1, `half_full`=0 and `q_vld`=0.
- R2: `mode_sel` is sampled only while `mrst_n` is low (0 = standard timing, 1 = fall-through timing). Changing it afterwards has no effect, and a partial reset does not sample it.
- R3: In standard timing, `rd_stat` is 1 exactly when the memory holds unread words (0 means empty). `q` changes only on an accepted read, which loads the oldest word.
- R4: In fall-through timing, the oldest word is loaded into `q` with no read request, and `rd_stat` is 1 while `q` holds such a word. An accepted read replaces it with the next word, or drops `rd_stat` to 0 if none is stored.
- R5: A read request is accepted only when `ren` and `rcs` are both 1 at a rising `rclk` edge.
- R6: A write while the memory is full is ignored and does not move the write pointer. A read while empty is ignored and leaves `q` and the read pointer unchanged.
- R7: `wr_stat` is 1 while the memory has room and 0 when it holds DEPTH words.
- R8: `half_full` is 1 when the memory holds more than DEPTH/2 words.
- R9: `rt`=1 at a rising `rclk` edge sets the read pointer to zero and forces `rd_stat` to 0 for the following cycle. Later reads restart from the first word written since reset. The write pointer and the configuration are unchanged, so later writes append after the existing data.
- R10: While `prst_n` is low, both pointers are cleared and `q` is all zeros. The latched timing mode is kept.
- R11: `q_vld` equals `oe` AND (the output register holds a word delivered since the last reset or retransmit, or in fall-through timing, a currently valid word).
- R12: Each clock domain sees the other domain's pointer only through a two-flop Gray-coded path. During normal operation the Gray write pointer changes by at most one bit per write-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, synchronous, active low, sampled in each domain |
| prst_n | input | 1 | Partial reset, synchronous, active low, keeps the mode |
| mode_sel | input | 1 | Timing mode select, sampled during master reset (1 = fall-through) |
| wen | input | 1 | Write enable |
| din | input | DW | Write data |
| wr_stat | output | 1 | 1 = room for a write |
| half_full | output | 1 | 1 = more than DEPTH/2 words stored |
| ren | input | 1 | Read enable |
| rcs | input | 1 | Read chip select, must be 1 for a read |
| rt | input | 1 | Retransmit request |
| oe | input | 1 | Output enable, qualifies `q_vld` |
| q | output | DW | Registered read data |
| q_vld | output | 1 | Output word valid and enabled |
| rd_stat | output | 1 | Standard: 1 = not empty; fall-through: 1 = `q` valid |

## Verification
The bench fills the memory to DEPTH words and writes once more. A design that let this write through would return the extra word after the eight stored ones. It checks the half-full boundary between DEPTH/2 and DEPTH/2+1 words, where an off-by-one compare flips the flag one word early. Retransmit is tested in both timing modes: a design that did not force the status low, or that also rewound the write pointer, shows a high status right after the request, or loses the word appended after it. A read with chip select low and a mode-pin change followed by a partial reset catch designs that ignore the select or resample the mode.

// File: rtl/fifo_rt_pkg.sv
// Shared definitions for the dual-clock retransmit FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package fifo_rt_pkg;

    // Output timing selected at master reset
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

endpackage

// File: rtl/fifo_rt_gsync.sv
// Two-flop synchronizer for a Gray-coded pointer, followed by Gray-to-binary
// conversion in the destination domain.
// Assumes: the source drives gray_in from a register, so only one bit moves
// per source cycle in normal operation.
module fifo_rt_gsync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two register stages in the destination clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Convert the synchronized Gray value back to binary
    always_comb begin
        bin_out[W-1] = stage2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2[i];
        end
    end

endmodule

// File: rtl/fifo_rt_wctl.sv
// Write-side control: write pointer, Gray copy for the read domain,
// space-available status and half-full flag.
// Assumes: rptr_s is the read pointer already synchronized to this clock;
// both resets are synchronous and active low.
module fifo_rt_wctl #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          wen,
    input  logic [AW:0]   rptr_s,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          we,
    output logic          wr_stat,
    output logic          half_full
);

    localparam int          DEPTH  = 1 << AW;
    localparam logic [AW:0] FULL_W = (AW+1)'(DEPTH);
    localparam logic [AW:0] HALF_W = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] ONE_W  = (AW+1)'(1);

    logic          rst_n;
    logic [AW:0]   wptr;
    logic [AW:0]   wptr_nxt;
    logic [AW:0]   count;
    logic          full;

    // Either reset clears the write side
    assign rst_n = mrst_n & prst_n;

    // Occupancy and flags from the local pointer and the synchronized one
    always_comb begin
        wptr_nxt  = wptr + ONE_W;
        count     = wptr - rptr_s;
        full      = (count == FULL_W);
        half_full = (count > HALF_W);
        wr_stat   = !full;
        we        = wen && !full;
        waddr     = wptr[AW-1:0];
    end

    // Advance binary and Gray pointers on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (we) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // R6
    write_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && full) |=> $stable(wptr));

    // R12
    wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R8
    full_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |-> half_full);

endmodule

// File: rtl/fifo_rt_rctl.sv
// Read-side control: timing-mode latch, read pointer, output register,
// fall-through prefetch, retransmit and read status.
// Assumes: wptr_s is the write pointer synchronized to this clock; rdata is
// the memory word at raddr, available in the same cycle. After a retransmit
// the write side sees the rewound pointer two cycles later, so writes are
// expected to pause briefly around a retransmit.
module fifo_rt_rctl
    import fifo_rt_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_in,
    input  logic          ren,
    input  logic          rcs,
    input  logic          rt,
    input  logic [AW:0]   wptr_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q,
    output logic          rd_stat,
    output logic          held
);

    localparam logic [AW:0] ONE_W = (AW+1)'(1);

    fifo_mode_e    mode_q;
    logic          rst_n;
    logic [AW:0]   rptr;
    logic [AW:0]   rptr_nxt;
    logic          fwft;
    logic          mem_empty;
    logic          rd_req;
    logic          pop;
    logic          out_valid;
    logic          std_held;
    logic          rt_hold;

    assign rst_n = mrst_n & prst_n;

    // Latch the timing mode only while master reset is held
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= fifo_mode_e'(mode_in);
        end
    end

    // Pop decision for both timing modes
    always_comb begin
        fwft      = (mode_q == MODE_FWFT);
        mem_empty = (rptr == wptr_s);
        rd_req    = ren && rcs;
        rptr_nxt  = rptr + ONE_W;
        if (rt || mem_empty) begin
            pop = 1'b0;
        end else if (fwft) begin
            pop = !out_valid || rd_req;
        end else begin
            pop = rd_req;
        end
        raddr   = rptr[AW-1:0];
        rd_stat = fwft ? out_valid : (!mem_empty && !rt_hold);
        held    = fwft ? out_valid : std_held;
    end

    // Pointer, output register and valid tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr      <= '0;
            rgray     <= '0;
            q         <= '0;
            out_valid <= 1'b0;
            std_held  <= 1'b0;
            rt_hold   <= 1'b0;
        end else if (rt) begin
            rptr      <= '0;
            rgray     <= '0;
            out_valid <= 1'b0;
            std_held  <= 1'b0;
            rt_hold   <= 1'b1;
        end else begin
            rt_hold <= 1'b0;
            if (pop) begin
                rptr     <= rptr_nxt;
                rgray    <= rptr_nxt ^ (rptr_nxt >> 1);
                q        <= rdata;
                std_held <= 1'b1;
            end
            if (fwft) begin
                if (pop) begin
                    out_valid <= 1'b1;
                end else if (rd_req) begin
                    out_valid <= 1'b0;
                end
            end
        end
    end

    // R9
    retransmit_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> (rptr == '0 && !rd_stat));

    // R5
    rcs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && !(ren && rcs) && !rt) |=> ($stable(rptr) && $stable(q)));

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STD && mem_empty && !rt) |=> $stable(rptr));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        $stable(mode_q));

endmodule

// File: rtl/fifo_rt_top.sv
// Dual-clock FIFO top: storage array, write and read control, and the two
// Gray-code pointer synchronizers.
// Assumes: DEPTH = 2**AW; both resets are held for several cycles of both
// clocks, and the mode input is stable while master reset is low.
module fifo_rt_top #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wen,
    input  logic [DW-1:0] din,
    output logic          wr_stat,
    output logic          half_full,
    input  logic          ren,
    input  logic          rcs,
    input  logic          rt,
    input  logic          oe,
    output logic [DW-1:0] q,
    output logic          q_vld,
    output logic          rd_stat
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW:0]   wgray;
    logic [AW:0]   rgray;
    logic [AW:0]   wptr_s;
    logic [AW:0]   rptr_s;
    logic          we;
    logic          held;
    logic          rst_n;

    assign rst_n = mrst_n & prst_n;

    // Storage write port in the write domain
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= din;
        end
    end

    fifo_rt_wctl #(.AW(AW)) i_wctl (
        .clk       (wclk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .wen       (wen),
        .rptr_s    (rptr_s),
        .waddr     (waddr),
        .wgray     (wgray),
        .we        (we),
        .wr_stat   (wr_stat),
        .half_full (half_full)
    );

    fifo_rt_rctl #(.DW(DW), .AW(AW)) i_rctl (
        .clk     (rclk),
        .mrst_n  (mrst_n),
        .prst_n  (prst_n),
        .mode_in (mode_sel),
        .ren     (ren),
        .rcs     (rcs),
        .rt      (rt),
        .wptr_s  (wptr_s),
        .rdata   (mem[raddr]),
        .raddr   (raddr),
        .rgray   (rgray),
        .q       (q),
        .rd_stat (rd_stat),
        .held    (held)
    );

    fifo_rt_gsync #(.W(AW+1)) i_w2r (
        .clk     (rclk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wptr_s)
    );

    fifo_rt_gsync #(.W(AW+1)) i_r2w (
        .clk     (wclk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rptr_s)
    );

    // Data-valid qualifier from the output enable
    assign q_vld = oe & held;

endmodule

// File: tb/test_fifo_rt_top.sv
// Directed bench for the dual-clock retransmit FIFO.
module test_fifo_rt_top;

    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD * 7 / 5;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          mode_sel = 1'b0;
    logic          wen = 1'b0;
    logic [DW-1:0] din = '0;
    logic          wr_stat;
    logic          half_full;
    logic          ren = 1'b0;
    logic          rcs = 1'b1;
    logic          rt = 1'b0;
    logic          oe = 1'b1;
    logic [DW-1:0] q;
    logic          q_vld;
    logic          rd_stat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    fifo_rt_top #(.DW(DW), .AW(AW)) i_fifo_rt_top (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .wen(wen), .din(din), .wr_stat(wr_stat),
        .half_full(half_full), .ren(ren), .rcs(rcs), .rt(rt), .oe(oe),
        .q(q), .q_vld(q_vld), .rd_stat(rd_stat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic mreset(input logic m);
        mode_sel = m;
        mrst_n = 1'b0;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        mrst_n = 1'b1;
        settle();
    endtask

    task automatic wr(input logic [DW-1:0] v);
        @(negedge wclk);
        wen = 1'b1;
        din = v;
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic rd();
        @(negedge rclk);
        ren = 1'b1;
        rcs = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
    endtask

    task automatic t_reset();
        mreset(1'b0);
        check("R1 q", q, 0);
        check("R1 rd_stat", rd_stat, 0);
        check("R1 wr_stat", wr_stat, 1);
        check("R1 half_full", half_full, 0);
        check("R1 q_vld", q_vld, 0);
    endtask

    task automatic t_std_rcs();
        wr(16'hA001); wr(16'hA002); wr(16'hA003);
        settle();
        check("R3 not empty", rd_stat, 1);
        check("R3 no fall-through", q, 0);
        rd();
        check("R3 first word", q, 16'hA001);
        check("R11 q_vld with oe", q_vld, 1);
        oe = 1'b0; #1;
        check("R11 q_vld oe low", q_vld, 0);
        oe = 1'b1;
        @(negedge rclk); ren = 1'b1; rcs = 1'b0;
        @(negedge rclk); ren = 1'b0; rcs = 1'b1;
        check("R5 rcs low read ignored", q, 16'hA001);
        rd();
        check("R5 next word after gated read", q, 16'hA002);
        rd();
        check("R3 third word", q, 16'hA003);
        settle();
        check("R3 empty", rd_stat, 0);
        rd();
        check("R6 read on empty keeps q", q, 16'hA003);
    endtask

    task automatic t_fill();
        mreset(1'b0);
        for (int i = 0; i < DEPTH / 2; i++) wr(16'hB000 + 16'(i));
        settle();
        check("R8 half_full at DEPTH/2", half_full, 0);
        wr(16'hB000 + 16'(DEPTH / 2));
        settle();
        check("R8 half_full above DEPTH/2", half_full, 1);
        for (int i = DEPTH / 2 + 1; i < DEPTH; i++) wr(16'hB000 + 16'(i));
        settle();
        check("R7 full", wr_stat, 0);
        wr(16'hDEAD);
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            check("R6 data order", q, 16'hB000 + 16'(i));
        end
        settle();
        check("R6 write when full dropped", rd_stat, 0);
        check("R7 room again", wr_stat, 1);
    endtask

    task automatic t_rt_std();
        mreset(1'b0);
        wr(16'hC000); wr(16'hC001); wr(16'hC002);
        settle();
        rd(); rd();
        check("R9 before rewind", q, 16'hC001);
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        check("R9 status forced empty", rd_stat, 0);
        check("R9 write side untouched", wr_stat, 1);
        settle();
        check("R9 data available again", rd_stat, 1);
        rd();
        check("R9 first word again", q, 16'hC000);
        wr(16'hC003);
        settle();
        rd(); check("R9 second word", q, 16'hC001);
        rd(); check("R9 third word", q, 16'hC002);
        rd(); check("R9 appended word", q, 16'hC003);
    endtask

    task automatic t_fwft();
        mreset(1'b1);
        check("R4 empty not ready", rd_stat, 0);
        wr(16'hD000);
        settle();
        check("R4 fall-through data", q, 16'hD000);
        check("R2 fall-through selected", rd_stat, 1);
        wr(16'hD001);
        settle();
        rd();
        check("R4 read advances", q, 16'hD001);
        rd();
        check("R4 drained not ready", rd_stat, 0);
        wr(16'hD002);
        settle();
        check("R4 refill", q, 16'hD002);
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        check("R9 fall-through not ready after rewind", rd_stat, 0);
        settle();
        check("R9 fall-through first word", q, 16'hD000);
        check("R9 fall-through ready", rd_stat, 1);
    endtask

    task automatic t_prst();
        mode_sel = 1'b0;
        settle();
        prst_n = 1'b0;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        prst_n = 1'b1;
        settle();
        check("R10 q cleared", q, 0);
        check("R10 empty", rd_stat, 0);
        check("R10 room", wr_stat, 1);
        wr(16'hE000);
        settle();
        check("R10 mode kept", q, 16'hE000);
        check("R2 pin change ignored", rd_stat, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_std_rcs();
        t_fill();
        t_rt_std();
        t_fwft();
        t_prst();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule